// File: doc/BRIEF.md
# MII Management Register Front-End

This block is the management register window of an Ethernet MAC. Software reaches it over a simple word-addressed register bus. Through it, software selects a PHY and a PHY register, starts read cycles, issues write cycles and collects read results. No serial management wire is driven. Every transaction completes at once against a small PHY register model held inside the block.

That model keeps a 16-bit control word and a 16-bit status word. It returns a fixed "receivers OK" pattern for one register and zero for every register it does not model. When the control word is written, its self-clearing bits are dropped. The link bit of the status word follows a link-down input.

A read cycle starts when software sets the read-request bit of the command register. A write cycle starts when software writes the data register. The block also carries a small set of general registers that behave according to their access type. The register bus has no handshake: a write takes effect on the clock edge where the write enable is high, and read data is a combinational function of the bus address.

Top module: `mii_mgmt_front`

## Requirements
- R1: After reset, every bus register reads 0, and the stored PHY control word is 0.
- R2: The command register (index 0) stores the full written value. A PHY read cycle starts only on a command write that changes bit 0 from 0 to 1. Writing bit 0 as 1 while it is already 1 leaves the read result unchanged.
- R3: A read cycle to PHY register 0 returns the stored PHY control word.
- R4: A read cycle to PHY register 1 returns the status word. Its bit 2 is 1 when link_down was low at the previous clock edge and 0 when it was high. All other bits of the status word are 0. The link bit tracks from the first cycle after reset.
- R5: A read cycle to PHY register 10 returns 0x1800. A read cycle to any other PHY register number returns 0.
- R6: The read result is loaded into the low 16 bits of the result register (index 3) on the edge of the command write. A bus read in the very next cycle sees it. The upper bits read 0.
- R7: A write to the data register (index 2) keeps only bits 15:0. Bits 31:16 read back as 0.
- R8: A write to the data register also performs a write cycle at once. If the addressed PHY register (address register bits 4:0) is 0, the control word takes the value with bits 15 and 8 cleared. For any other PHY register the write cycle changes nothing.
- R9: The address register (index 1) stores the full written value. The PHY number in bits 12:8 has no effect on read or write cycles.
- R10: The general registers follow their access type. Index 4 is read-write. Index 5 is write-1-to-clear: bits written as 1 clear and no bit is ever set by a write. Index 6 is read-only and ignores writes. Indices 7 to 15 read 0.
- R11: Bus writes to the result register (index 3) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word index of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| link_down | input | 1 | High while the Ethernet link is down |

## Verification
Read cycles are run against PHY register 0 after several control writes. Each write places set bits both inside and outside the self-clearing mask, so the test separates a correct mask from a missing or wrong one. Write cycles are also aimed at a non-control PHY register, which shows whether the write is ignored. Status reads are taken with the link both up and down. Register 10 is read with two different PHY numbers and compared against an unmodelled register, which shows whether the PHY number and the register decode are handled correctly. The command bit is rewritten as 1 while already set, with a changed control word underneath, so a level-triggered read start would show up as a changed result.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

  typedef enum logic [1:0] {
    AT_RW  = 2'd0,
    AT_WO  = 2'd1,
    AT_W1C = 2'd2,
    AT_RO  = 2'd3
  } acc_t;

  localparam int PHY_DATA_W = 16;
  localparam int PHY_SEL_W  = 5;

  // bus register indices
  localparam int IDX_CMD  = 0;
  localparam int IDX_ADR  = 1;
  localparam int IDX_DAT  = 2;
  localparam int IDX_RES  = 3;
  localparam int IDX_EXT0 = 4;
  localparam int N_EXT    = 3;

  localparam int CMD_RD_BIT = 0;

  // PHY model register numbers and constants
  localparam logic [PHY_SEL_W-1:0]  PREG_CTRL  = 5'd0;
  localparam logic [PHY_SEL_W-1:0]  PREG_STAT  = 5'd1;
  localparam logic [PHY_SEL_W-1:0]  PREG_RXOK  = 5'd10;
  localparam logic [PHY_DATA_W-1:0] RXOK_VALUE = 16'h1800;
  localparam logic [PHY_DATA_W-1:0] SELFCLR_MASK = 16'h8100;
  localparam int STAT_LINK_BIT = 2;

  function automatic acc_t ext_access(input int idx);
    case (idx)
      0:       return AT_RW;
      1:       return AT_W1C;
      default: return AT_RO;
    endcase
  endfunction

endpackage

// File: rtl/mmf_access_reg.sv
module mmf_access_reg import mmf_pkg::*; #(
  parameter int              W   = 32,
  parameter acc_t            ACC = AT_RW,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST;
    end else if (wr_en) begin
      case (ACC)
        AT_RW, AT_WO: q <= wdata;
        AT_W1C:       q <= q & ~wdata;
        default:      q <= q;
      endcase
    end
  end

  assign rd_val = (ACC == AT_WO) ? '0 : q;

  if (ACC == AT_W1C) begin : g_w1c_chk
    AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((q & ~$past(q)) == '0));  // R10
  end

endmodule

// File: rtl/mmf_phy_model.sv
module mmf_phy_model import mmf_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_down,
  input  logic [PHY_SEL_W-1:0]  rd_sel,
  output logic [PHY_DATA_W-1:0] rd_data,
  input  logic                  wr_en,
  input  logic [PHY_SEL_W-1:0]  wr_sel,
  input  logic [PHY_DATA_W-1:0] wr_data
);

  logic [PHY_DATA_W-1:0] ctrl_word;
  logic                  link_up_q;
  logic [PHY_DATA_W-1:0] status_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
    end else if (wr_en && wr_sel == PREG_CTRL) begin
      ctrl_word <= wr_data & ~SELFCLR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_up_q <= 1'b0;
    else        link_up_q <= ~link_down;
  end

  always_comb begin
    status_word = '0;
    status_word[STAT_LINK_BIT] = link_up_q;
  end

  always_comb begin
    case (rd_sel)
      PREG_CTRL: rd_data = ctrl_word;
      PREG_STAT: rd_data = status_word;
      PREG_RXOK: rd_data = RXOK_VALUE;
      default:   rd_data = '0;
    endcase
  end

  AST_CTRL_ONLY_REG0: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word != $past(ctrl_word)) |-> $past(wr_en && wr_sel == PREG_CTRL));  // R8

  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_word[STAT_LINK_BIT] == !$past(link_down)));  // R4

endmodule

// File: rtl/mii_mgmt_front.sv
module mii_mgmt_front import mmf_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              link_down
);

  int sel;
  assign sel = int'(bus_addr);

  logic [DATA_W-1:0]     cmd_q;
  logic [DATA_W-1:0]     adr_q;
  logic [PHY_DATA_W-1:0] dat_q;
  logic [PHY_DATA_W-1:0] res_q;
  logic [DATA_W-1:0]     ext_q [N_EXT];

  logic                  cmd_wr, adr_wr, dat_wr, rd_go;
  logic [PHY_DATA_W-1:0] phy_rd_data;
  logic [PHY_SEL_W-1:0]  phy_sel;

  assign cmd_wr  = bus_we && (sel == IDX_CMD);
  assign adr_wr  = bus_we && (sel == IDX_ADR);
  assign dat_wr  = bus_we && (sel == IDX_DAT);
  assign rd_go   = cmd_wr && bus_wdata[CMD_RD_BIT] && !cmd_q[CMD_RD_BIT];
  assign phy_sel = adr_q[PHY_SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
      res_q <= '0;
    end else begin
      if (cmd_wr) cmd_q <= bus_wdata;
      if (adr_wr) adr_q <= bus_wdata;
      if (dat_wr) dat_q <= bus_wdata[PHY_DATA_W-1:0];
      if (rd_go)  res_q <= phy_rd_data;
    end
  end

  mmf_phy_model u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_down (link_down),
    .rd_sel    (phy_sel),
    .rd_data   (phy_rd_data),
    .wr_en     (dat_wr),
    .wr_sel    (phy_sel),
    .wr_data   (bus_wdata[PHY_DATA_W-1:0])
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    mmf_access_reg #(
      .W   (DATA_W),
      .ACC (ext_access(g)),
      .RST ('0)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_we && (sel == IDX_EXT0 + g)),
      .wdata  (bus_wdata),
      .rd_val (ext_q[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (sel == IDX_CMD) bus_rdata = cmd_q;
    if (sel == IDX_ADR) bus_rdata = adr_q;
    if (sel == IDX_DAT) bus_rdata[PHY_DATA_W-1:0] = dat_q;
    if (sel == IDX_RES) bus_rdata[PHY_DATA_W-1:0] = res_q;
    for (int i = 0; i < N_EXT; i++) begin
      if (sel == IDX_EXT0 + i) bus_rdata = ext_q[i];
    end
  end

  AST_READ_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> $past(rd_go));  // R2

  AST_RXOK_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && phy_sel == PREG_RXOK) |=> (res_q == RXOK_VALUE));  // R5

endmodule

// File: tb/mii_mgmt_front_tb.sv
module mii_mgmt_front_tb;
  import mmf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        link_down;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];
  logic chk_req = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mii_mgmt_front u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .link_down (link_down)
  );

  // monitor: compares bus reads against the scoreboard queue
  always @(negedge clk) begin
    exp_t e;
    if (chk_req) begin
      e = sb.pop_front();
      total++;
      if (bus_rdata !== e.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, bus_rdata, e.exp);
      end
      chk_req = 1'b0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  // read in the cycle that follows the last write edge
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    bus_addr = a; bus_we = 1'b0;
    sb.push_back(e);
    chk_req = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic phy_read();
    wr(4'(IDX_CMD), 32'h0);
    wr(4'(IDX_CMD), 32'h1);
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_down = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 0; i < 7; i++) rd(4'(i), 32'h0, "R1 reset reg");
    phy_read();
    rd(4'(IDX_RES), 32'h0, "R1 control word reset");

    // R7, R8 masked control write, R3 read back, R6 next-cycle visibility
    wr(4'(IDX_ADR), 32'h0);
    wr(4'(IDX_DAT), 32'hFFFF_FFFF);
    rd(4'(IDX_DAT), 32'h0000_FFFF, "R7 data low half");
    phy_read();
    rd(4'(IDX_RES), 32'h0000_7EFF, "R3 R6 R8 masked control");
    rd(4'(IDX_CMD), 32'h1, "R2 command stored");

    // R2 no restart while bit already set
    wr(4'(IDX_DAT), 32'h1234);
    wr(4'(IDX_CMD), 32'h3);
    rd(4'(IDX_RES), 32'h0000_7EFF, "R2 no read on held bit");
    rd(4'(IDX_CMD), 32'h3, "R2 command full value");
    phy_read();
    rd(4'(IDX_RES), 32'h0000_1234, "R2 R3 read after re-arm");

    // R4 link status
    wr(4'(IDX_ADR), 32'h1);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_0004, "R4 link up");
    link_down = 1'b1;
    phy_read();
    rd(4'(IDX_RES), 32'h0000_0000, "R4 link down");
    link_down = 1'b0;
    phy_read();
    rd(4'(IDX_RES), 32'h0000_0004, "R4 link restored");

    // R5, R9 constant register and PHY number
    wr(4'(IDX_ADR), 32'h0000_000A);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_1800, "R5 receivers ok");
    wr(4'(IDX_ADR), 32'h0000_0003);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_0000, "R5 unmodelled reg");
    wr(4'(IDX_ADR), 32'h0000_1F0A);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_1800, "R9 phy number ignored on read");
    rd(4'(IDX_ADR), 32'h0000_1F0A, "R9 address stored");

    // R8 write to other PHY register ignored
    wr(4'(IDX_ADR), 32'h0000_0005);
    wr(4'(IDX_DAT), 32'h0000_AAAA);
    rd(4'(IDX_DAT), 32'h0000_AAAA, "R7 data stored");
    wr(4'(IDX_ADR), 32'h0);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_1234, "R8 other reg write ignored");

    // R9 PHY number ignored on write
    wr(4'(IDX_ADR), 32'h0000_1500);
    wr(4'(IDX_DAT), 32'hABCD_8155);
    phy_read();
    rd(4'(IDX_RES), 32'h0000_0055, "R8 R9 write with phy number");

    // R11 result register read-only
    wr(4'(IDX_RES), 32'hFFFF_FFFF);
    rd(4'(IDX_RES), 32'h0000_0055, "R11 result write ignored");

    // R10 general registers
    wr(4'(IDX_EXT0), 32'hDEAD_BEEF);
    rd(4'(IDX_EXT0), 32'hDEAD_BEEF, "R10 read-write");
    wr(4'(IDX_EXT0 + 1), 32'hFFFF_FFFF);
    rd(4'(IDX_EXT0 + 1), 32'h0, "R10 w1c never set");
    wr(4'(IDX_EXT0 + 2), 32'h5A5A_5A5A);
    rd(4'(IDX_EXT0 + 2), 32'h0, "R10 read-only");
    wr(4'd9, 32'h1111_1111);
    rd(4'd9, 32'h0, "R10 unmapped");

    @(posedge clk); #1;
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule